// File: doc/BRIEF.md
# Timer with match and capture

A 32-bit up-counter driven by a 32-bit prescaler. The prescaler steps either on every clock (timer mode) or on each synchronized rising edge of an external count input (event mode), and the counter advances each time the prescaler reaches its limit. Four compare channels watch the counter. On a hit, each channel can raise an interrupt flag, restart the counter, halt it, and drive its own output pin with a programmable action.

Four capture channels synchronize their inputs through two flops. On the edge or edges chosen for each channel, it copies the counter into a read-only register and, if enabled, raises a flag. A single status register holds all eight flags, and each flag is cleared by writing 1 to it. The interrupt output is high while any flag is set. Software reaches every register through a single-cycle write strobe and a combinational read port, using word addresses 0 to 15.

Register map (word addresses): 0 CTRL (bit0 run, bit1 hold, bit2 event mode), 1 FLAGS (bits 3:0 compare channels, bits 7:4 capture channels), 2 COUNT, 3 PLIM (prescale limit), 4 PCNT (prescale count, read-only), 5 MACT (per-channel compare actions), 6 OACT (per-channel output actions), 7 CCFG (per-channel capture setup), 8 to 11 compare values for channels 0 to 3, 12 to 15 capture values for channels 0 to 3.

Top module: `tmr_match_capture`

## Requirements
- R1: After reset, every register reads 0, `match_out` is 4'b0000 and `irq` is 0.
- R2: In timer mode with CTRL bit0 set, the prescaler counts clocks. When PCNT is greater than or equal to PLIM, PCNT returns to 0 and COUNT advances by one, so that E enabled clocks give COUNT = E/(PLIM+1) and PCNT = E mod (PLIM+1).
- R3: In event mode (CTRL bit2 set), the prescaler steps only once per rising edge of `count_in` after a two-flop synchronizer, with the same division as in R2.
- R4: While CTRL bit1 (hold) is set, COUNT and PCNT are forced to 0 on the following clock.
- R5: A write to COUNT loads it. Counting past all-ones wraps to 0.
- R6: A compare channel hits on the tick that makes COUNT equal to its compare value. Its flag is set only when its MACT bit 3i (interrupt) is 1.
- R7: When MACT bit 3i+1 (restart) is set, the tick after a hit returns COUNT to 0, so COUNT holds the compare value for a full prescale period and cycles through M+1 values.
- R8: When MACT bit 3i+2 (halt) is set, a hit clears CTRL bit0 and COUNT stays at the compare value.
- R9: On a hit, channel i applies the action in OACT bits [2i+1:2i] to `match_out[i]`: 00 leave unchanged, 01 drive low, 10 drive high, 11 invert.
- R10: CCFG bits [3i+2:3i] = {interrupt, falling, rising} for capture channel i. A selected edge of `cap_in[i]`, after synchronization, copies COUNT into the channel's capture register and sets FLAGS bit 4+i if interrupt is 1.
- R11: An edge that is not selected leaves the capture register and the flag unchanged.
- R12: Writing FLAGS clears each bit written as 1 and leaves bits written as 0. `irq` equals the OR of FLAGS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| count_in | input | 1 | External count input for event mode |
| cap_in | input | 4 | Capture inputs |
| match_out | output | 4 | Compare-driven outputs |
| irq | output | 1 | Interrupt, high while any flag is set |

## Verification
Counting is tried with a free-running clock at a prescale limit of 2 and with pulse trains on the count input at limits 0 and 1. These runs separate the quotient from the remainder, and separate the count source from the division. A run near all-ones checks the wrap.

One compare channel halts the counter, while others restart it, invert an output, set outputs and clear outputs. The tick counts are chosen so that an off-by-one in the restart period, or in the number of inversions, shows up in COUNT and in `match_out`.

Capture channels are set to rising, falling, both edges and no edge, and are driven with a rising and then a falling step while the counter is loaded with distinct values. This shows which channels latched on each step and which ones flagged.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH = 4;
  localparam int AW  = 4;
  localparam int DW  = 32;

  localparam logic [AW-1:0] A_CTRL  = 4'h0;
  localparam logic [AW-1:0] A_FLAGS = 4'h1;
  localparam logic [AW-1:0] A_COUNT = 4'h2;
  localparam logic [AW-1:0] A_PLIM  = 4'h3;
  localparam logic [AW-1:0] A_PCNT  = 4'h4;
  localparam logic [AW-1:0] A_MACT  = 4'h5;
  localparam logic [AW-1:0] A_OACT  = 4'h6;
  localparam logic [AW-1:0] A_CCFG  = 4'h7;
  localparam logic [AW-1:0] A_MVAL  = 4'h8;
  localparam logic [AW-1:0] A_CVAL  = 4'hC;

  typedef enum logic [1:0] {
    OUT_KEEP   = 2'b00,
    OUT_LOW    = 2'b01,
    OUT_HIGH   = 2'b10,
    OUT_INVERT = 2'b11
  } out_act_e;

  function automatic logic next_pin(input logic cur, input out_act_e act);
    case (act)
      OUT_LOW:    return 1'b0;
      OUT_HIGH:   return 1'b1;
      OUT_INVERT: return ~cur;
      default:    return cur;
    endcase
  endfunction

  function automatic logic [DW-1:0] count_target(input logic [DW-1:0] cur, input logic restart);
    return restart ? '0 : cur + 1'b1;
  endfunction
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sr;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      last <= 1'b0;
    end else begin
      sr   <= {sr[STAGES-2:0], din};
      last <= sr[STAGES-1];
    end
  end

  assign rise = sr[STAGES-1] & ~last;
  assign fall = ~sr[STAGES-1] & last;
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] lim,
  output logic [W-1:0] pcnt,
  output logic         tick
);
  assign tick = step && (pcnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pcnt <= '0;
    else if (clr)   pcnt <= '0;
    else if (step)  pcnt <= tick ? '0 : pcnt + 1'b1;
  end
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise,
  input  logic         fall,
  input  logic         sel_rise,
  input  logic         sel_fall,
  input  logic [W-1:0] count,
  output logic [W-1:0] cap_val,
  output logic         hit
);
  assign hit = (rise & sel_rise) | (fall & sel_fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cap_val <= '0;
    else if (hit) cap_val <= count;
  end
endmodule

// File: rtl/tmr_match_capture.sv
module tmr_match_capture
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          count_in,
  input  logic [NCH-1:0] cap_in,
  output logic [NCH-1:0] match_out,
  output logic          irq
);
  localparam int NFLAG = 2 * NCH;

  logic ctrl_en, ctrl_hold, ctrl_evt;
  logic [DW-1:0]      count, plim, pcnt;
  logic [NFLAG-1:0]   flags, flag_set, flag_clr;
  logic [3*NCH-1:0]   mact, ccfg;
  logic [2*NCH-1:0]   oact;
  logic [DW-1:0]      mval    [NCH];
  logic [DW-1:0]      cap_val [NCH];
  logic [NCH-1:0]     eq, match_evt, cap_hit, cap_rise, cap_fall;
  logic [NCH-1:0]     m_irq, m_restart, m_halt, c_irq;
  logic               cnt_rise, cnt_fall_unused, step, tick, restart_hit, halt_hit;
  logic [DW-1:0]      target;

  logic wr_ctrl, wr_flags, wr_count;
  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_flags = reg_wr && (reg_addr == A_FLAGS);
  assign wr_count = reg_wr && (reg_addr == A_COUNT);

  // count input synchronizer
  tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .din(count_in), .rise(cnt_rise), .fall(cnt_fall_unused)
  );

  assign step = ctrl_en && !ctrl_hold && (ctrl_evt ? cnt_rise : 1'b1);

  tmr_prescale #(.W(DW)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(ctrl_hold), .step(step),
    .lim(plim), .pcnt(pcnt), .tick(tick)
  );

  // per-channel compare decode
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      m_irq[i]     = mact[3*i];
      m_restart[i] = mact[3*i+1];
      m_halt[i]    = mact[3*i+2];
      c_irq[i]     = ccfg[3*i+2];
      eq[i]        = (count == mval[i]);
    end
  end

  assign restart_hit = tick && |(eq & m_restart);
  assign target      = count_target(count, restart_hit);

  always_comb begin
    for (int i = 0; i < NCH; i++) match_evt[i] = tick && (target == mval[i]);
  end

  assign halt_hit = |(match_evt & m_halt);

  // control, counter, config registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ctrl_evt, ctrl_hold, ctrl_en} <= '0;
      count <= '0;
      plim  <= '0;
      mact  <= '0;
      oact  <= '0;
      ccfg  <= '0;
    end else begin
      if (wr_ctrl)       {ctrl_evt, ctrl_hold, ctrl_en} <= reg_wdata[2:0];
      else if (halt_hit) ctrl_en <= 1'b0;

      if (ctrl_hold)     count <= '0;
      else if (wr_count) count <= reg_wdata;
      else if (tick)     count <= target;

      if (reg_wr && reg_addr == A_PLIM) plim <= reg_wdata;
      if (reg_wr && reg_addr == A_MACT) mact <= reg_wdata[3*NCH-1:0];
      if (reg_wr && reg_addr == A_OACT) oact <= reg_wdata[2*NCH-1:0];
      if (reg_wr && reg_addr == A_CCFG) ccfg <= reg_wdata[3*NCH-1:0];
    end
  end

  // per-channel compare values, outputs and capture
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mval[g]      <= '0;
        match_out[g] <= 1'b0;
      end else begin
        if (reg_wr && reg_addr == (A_MVAL | AW'(g))) mval[g] <= reg_wdata;
        if (match_evt[g]) match_out[g] <= next_pin(match_out[g], out_act_e'(oact[2*g+:2]));
      end
    end

    tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_cap_sync (
      .clk(clk), .rst_n(rst_n), .din(cap_in[g]), .rise(cap_rise[g]), .fall(cap_fall[g])
    );

    tmr_capture #(.W(DW)) u_cap (
      .clk(clk), .rst_n(rst_n), .rise(cap_rise[g]), .fall(cap_fall[g]),
      .sel_rise(ccfg[3*g]), .sel_fall(ccfg[3*g+1]), .count(count),
      .cap_val(cap_val[g]), .hit(cap_hit[g])
    );
  end

  // interrupt flags, set wins over clear
  assign flag_set = {cap_hit & c_irq, match_evt & m_irq};
  assign flag_clr = wr_flags ? reg_wdata[NFLAG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flag_set | (flags & ~flag_clr);
  end

  assign irq = |flags;

  // read port
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = DW'({ctrl_evt, ctrl_hold, ctrl_en});
      A_FLAGS: reg_rdata = DW'(flags);
      A_COUNT: reg_rdata = count;
      A_PLIM:  reg_rdata = plim;
      A_PCNT:  reg_rdata = pcnt;
      A_MACT:  reg_rdata = DW'(mact);
      A_OACT:  reg_rdata = DW'(oact);
      A_CCFG:  reg_rdata = DW'(ccfg);
      default: reg_rdata = reg_addr[2] ? cap_val[reg_addr[1:0]] : mval[reg_addr[1:0]];
    endcase
  end
endmodule

// File: rtl/tmr_match_capture_chk.sv
module tmr_match_capture_chk
  import tmr_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic [AW-1:0]  reg_addr,
  input logic [DW-1:0]  reg_wdata,
  input logic           ctrl_en,
  input logic           ctrl_hold,
  input logic [DW-1:0]  count,
  input logic [NCH-1:0] match_evt,
  input logic [NCH-1:0] m_halt,
  input logic [NCH-1:0] cap_hit,
  input logic [2*NCH-1:0] flags,
  input logic [2*NCH-1:0] flag_set,
  input logic [NCH-1:0] match_out,
  input logic           irq
);
  logic wr_ctrl, wr_flags, wr_count;
  assign wr_ctrl  = reg_wr && reg_addr == A_CTRL;
  assign wr_flags = reg_wr && reg_addr == A_FLAGS;
  assign wr_count = reg_wr && reg_addr == A_COUNT;

  // R8: a halting hit leaves the run bit clear
  a_r8_halt_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
    (|(match_evt & m_halt)) && !wr_ctrl |=> !ctrl_en);

  // R2: a stopped counter keeps its value
  a_r2_idle_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en && !ctrl_hold && !wr_count |=> $stable(count));

  // R9: outputs move only on a compare hit
  a_r9_out_only_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !(|match_evt) |=> $stable(match_out));

  // R12: a written 1 clears the flag when no event sets it
  a_r12_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flags |=> ((flags & $past(reg_wdata[2*NCH-1:0] & ~flag_set)) == '0));

  // R12: irq rises only after a flag-setting event
  a_r12_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|flag_set));

  // R4: hold forces the counter to zero
  a_r4_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hold |=> count == '0);
endmodule

bind tmr_match_capture tmr_match_capture_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .ctrl_en(ctrl_en), .ctrl_hold(ctrl_hold), .count(count), .match_evt(match_evt),
  .m_halt(m_halt), .cap_hit(cap_hit), .flags(flags), .flag_set(flag_set),
  .match_out(match_out), .irq(irq)
);

// File: tb/tmr_match_capture_tb.sv
module tmr_match_capture_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        count_in = 1'b0;
  logic [3:0]  cap_in = '0;
  logic [3:0]  match_out;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct { string tag; logic [31:0] exp; } exp_t;
  exp_t        exp_q[$];
  logic [31:0] obs_q[$];

  always #2 clk = ~clk;

  tmr_match_capture u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .count_in(count_in), .cap_in(cap_in),
    .match_out(match_out), .irq(irq)
  );

  // monitor: compares observations against expectations in order
  initial forever begin
    exp_t e; logic [31:0] o;
    wait (exp_q.size() > 0 && obs_q.size() > 0);
    e = exp_q.pop_front();
    o = obs_q.pop_front();
    n_tests++;
    if (o !== e.exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", e.tag, o, e.exp);
    end
  end

  task automatic expect_val(input string tag, input logic [31:0] got, input logic [31:0] exp);
    exp_q.push_back('{tag, exp});
    obs_q.push_back(got);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 expect_val(tag, reg_rdata, exp);
  endtask

  task automatic pin_check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    @(negedge clk);
    expect_val(tag, got, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_counter();
    wr(4'h0, 32'h2);
    idle(2);
    wr(4'h0, 32'h0);
  endtask

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) count_in = 1'b1;
      idle(3);
      @(negedge clk) count_in = 1'b0;
      idle(3);
    end
    idle(5);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd_check("R1 CTRL", 4'h0, 0);
    rd_check("R1 FLAGS", 4'h1, 0);
    rd_check("R1 COUNT", 4'h2, 0);
    rd_check("R1 PCNT", 4'h4, 0);
    rd_check("R1 MVAL0", 4'h8, 0);
    pin_check("R1 match_out", 32'(match_out), 0);
    pin_check("R1 irq", 32'(irq), 0);

    // R2 timer mode: 11 enabled clocks, limit 2 -> count 3, pcnt 2
    wr(4'h3, 2);
    wr(4'h0, 1);
    idle(10);
    wr(4'h0, 0);
    idle(2);
    rd_check("R2 COUNT quotient", 4'h2, 3);
    rd_check("R2 PCNT remainder", 4'h4, 2);

    // R4 hold forces zero
    wr(4'h0, 2);
    idle(2);
    rd_check("R4 COUNT held", 4'h2, 0);
    rd_check("R4 PCNT held", 4'h4, 0);
    wr(4'h0, 0);

    // R3 event mode, limit 0 then 1
    wr(4'h3, 0);
    wr(4'h0, 5);
    pulses(5);
    wr(4'h0, 4);
    rd_check("R3 COUNT events lim0", 4'h2, 5);
    wr(4'h3, 1);
    wr(4'h2, 0);
    wr(4'h0, 5);
    pulses(5);
    wr(4'h0, 4);
    rd_check("R3 COUNT events lim1", 4'h2, 2);
    rd_check("R3 PCNT events lim1", 4'h4, 1);

    // R5 load and wrap
    clear_counter();
    wr(4'h3, 0);
    wr(4'h2, 32'hFFFF_FFFE);
    rd_check("R5 COUNT load", 4'h2, 32'hFFFF_FFFE);
    wr(4'h0, 1);
    idle(2);
    wr(4'h0, 0);
    idle(1);
    rd_check("R5 COUNT wrap", 4'h2, 1);

    // R8 halt on match with R6 interrupt
    clear_counter();
    wr(4'h8, 7);
    wr(4'h5, 32'h5);
    wr(4'h0, 1);
    idle(20);
    rd_check("R8 run bit cleared", 4'h0, 0);
    rd_check("R8 COUNT at compare", 4'h2, 7);
    rd_check("R6 flag ch0", 4'h1, 32'h1);
    pin_check("R12 irq high", 32'(irq), 1);
    wr(4'h1, 32'h0);
    rd_check("R12 write 0 keeps", 4'h1, 32'h1);
    wr(4'h1, 32'h1);
    rd_check("R12 write 1 clears", 4'h1, 0);
    pin_check("R12 irq low", 32'(irq), 0);

    // R7 restart at 4 on ch1, R9 outputs
    clear_counter();
    wr(4'h5, 32'h18);
    wr(4'h9, 4);
    wr(4'hA, 2);
    wr(4'hB, 3);
    wr(4'h6, 32'hAC);
    wr(4'h0, 1);
    idle(13);
    wr(4'h0, 0);
    idle(1);
    rd_check("R7 COUNT after 14 ticks", 4'h2, 4);
    pin_check("R9 invert x3, high, high", 32'(match_out), 32'hE);
    rd_check("R6 only irq-enabled flag", 4'h1, 32'h2);
    wr(4'h6, 32'h6C);
    wr(4'h0, 1);
    idle(4);
    wr(4'h0, 0);
    idle(1);
    rd_check("R7 COUNT after 5 more ticks", 4'h2, 4);
    pin_check("R9 invert back, low", 32'(match_out), 32'h4);
    wr(4'h1, 32'hFF);
    rd_check("R12 all cleared", 4'h1, 0);

    // R10/R11 capture
    wr(4'h5, 0);
    wr(4'h2, 32'h1234);
    wr(4'h7, 32'h1D5);
    @(negedge clk) cap_in = 4'hF;
    idle(6);
    rd_check("R10 rising ch0", 4'hC, 32'h1234);
    rd_check("R11 falling-only ch1 on rise", 4'hD, 0);
    rd_check("R10 both ch2 rise", 4'hE, 32'h1234);
    rd_check("R11 none ch3", 4'hF, 0);
    rd_check("R10 capture flags", 4'h1, 32'h50);
    wr(4'h1, 32'hFF);
    wr(4'h2, 32'h55AA);
    @(negedge clk) cap_in = 4'h0;
    idle(6);
    rd_check("R11 rising-only ch0 on fall", 4'hC, 32'h1234);
    rd_check("R10 falling ch1", 4'hD, 32'h55AA);
    rd_check("R10 both ch2 fall", 4'hE, 32'h55AA);
    rd_check("R11 none ch3 fall", 4'hF, 0);
    rd_check("R10 flag only ch2", 4'h1, 32'h40);

    wait (exp_q.size() == 0 && obs_q.size() == 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule